// File: doc/BRIEF.md
# ADC Conversion Trigger and Result Delivery Controller

This block sits between a host register interface and an analog-to-digital converter. It decides when a conversion starts and how the host learns about the result. The host writes a small mode code. That code selects a trigger source: a software command, a periodic pacer tick, or a pin driven from outside the chip. It also selects a delivery path: polling, an interrupt request, or a DMA request. A static jumper input chooses between the internal and external trigger families, and it changes what each mode code means.

For every accepted trigger, the controller sends the converter a one-cycle start strobe. It keeps a busy flag that the host polls, and it ignores further triggers until the converter reports completion. At that point it raises the interrupt or DMA request that the current mode selects. Each request stays high until the host or the DMA controller acknowledges it. Writing a new mode cancels any request that is still pending.

Top module: `adc_trig_ctrl`

## Requirements
- R1: The mode code is taken from bits 2:0 of `mode_wdata` when `mode_we` is high, and it takes effect from the next cycle. Bits 7:3 have no effect on behaviour.
- R2: Mode 000, and the unused codes 011, 100, 101 and 111, issue no start strobe, raise no request and hold `poll_en` low, under either jumper setting.
- R3: With `ext_sel`=0, mode 001 accepts only `sw_trig` as a trigger and sets `poll_en`=1, with no interrupt and no DMA request. With `ext_sel`=1, mode 001 is fully disabled.
- R4: An accepted `sw_trig` or `pacer_tick` produces `adc_start` high for exactly one cycle, in the cycle after the trigger is sampled.
- R5: With `ext_sel`=0, mode 010 triggers on `pacer_tick` and raises `dma_req` at end of conversion, with `poll_en`=0. Mode 110 triggers on `pacer_tick`, raises `irq_req` at end of conversion, and sets `poll_en`=1.
- R6: With `ext_sel`=1, modes 010 and 110 use `ext_trig` in place of the pacer tick. `ext_trig` passes through two synchronizer flops and is detected on its rising edge, so one pulse of any length yields one strobe, two cycles after the first sampling edge. `pacer_tick` and `sw_trig` are ignored in these modes.
- R7: `adc_busy` goes to 1 together with `adc_start` and returns to 0 in the cycle after `adc_done` is seen. Triggers that arrive while `adc_busy` is 1 are dropped.
- R8: `irq_req` stays high until `irq_clr` or `data_rd` is sampled high. If an end of conversion arrives in the same cycle as a clear, the request stays set.
- R9: `dma_req` stays high until `dma_ack` is sampled high.
- R10: After reset the mode is 000 and all outputs are 0. A mode write clears `irq_req` and `dma_req` in the following cycle, and this takes priority over any other event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Written byte; only bits 2:0 are used |
| ext_sel | input | 1 | Jumper: 0 selects internal triggers, 1 selects the external trigger |
| sw_trig | input | 1 | Software trigger command pulse |
| pacer_tick | input | 1 | Periodic pacer pulse |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| adc_done | input | 1 | Converter end-of-conversion pulse |
| irq_clr | input | 1 | Host clears the interrupt request |
| data_rd | input | 1 | Host reads the conversion result |
| dma_ack | input | 1 | DMA acknowledge |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_busy | output | 1 | Status bit: 1 while a conversion is running |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| poll_en | output | 1 | High when the current mode allows polled reads |

## Verification
The assertions take three things for granted. `ext_sel` is static apart from reset. The converter pulses `adc_done` only while `adc_busy` is high. `dma_ack` arrives only while `dma_req` is high. The random stimulus follows all three rules. It holds the jumper fixed for each phase and changes it only across a reset. It drives `adc_done` only when the reference model says a conversion is running, and it drives `dma_ack` only when the model shows a pending DMA request. Mode writes carry random upper bits and are biased toward the three active codes, so that conversions actually happen.

// File: rtl/adc_tc_pkg.sv
package adc_tc_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_SOFT = 2'd1,
        SRC_PACE = 2'd2,
        SRC_PIN  = 2'd3
    } trig_src_e;

    typedef struct packed {
        trig_src_e src;
        logic      irq_en;
        logic      dma_en;
        logic      poll_en;
    } mode_cfg_t;

    localparam logic [MODE_W-1:0] CODE_SOFT_POLL = 3'b001;
    localparam logic [MODE_W-1:0] CODE_TICK_DMA  = 3'b010;
    localparam logic [MODE_W-1:0] CODE_TICK_IRQ  = 3'b110;
endpackage

// File: rtl/adc_tc_decode.sv
module adc_tc_decode
    import adc_tc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              ext_sel,
    output mode_cfg_t         cfg
);
    always_comb begin
        cfg = '{src: SRC_OFF, irq_en: 1'b0, dma_en: 1'b0, poll_en: 1'b0};
        unique case (mode)
            CODE_SOFT_POLL: begin
                if (!ext_sel) begin
                    cfg.src     = SRC_SOFT;
                    cfg.poll_en = 1'b1;
                end
            end
            CODE_TICK_DMA: begin
                cfg.src    = ext_sel ? SRC_PIN : SRC_PACE;
                cfg.dma_en = 1'b1;
            end
            CODE_TICK_IRQ: begin
                cfg.src     = ext_sel ? SRC_PIN : SRC_PACE;
                cfg.irq_en  = 1'b1;
                cfg.poll_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_tc_edge.sv
module adc_tc_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic [SH_W-1:0] sh_d;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < SH_W; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_tc_pkg::*;
#(
    parameter int BUS_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [BUS_W-1:0] mode_wdata,
    input  logic             ext_sel,
    input  logic             sw_trig,
    input  logic             pacer_tick,
    input  logic             ext_trig,
    input  logic             adc_done,
    input  logic             irq_clr,
    input  logic             data_rd,
    input  logic             dma_ack,
    output logic             adc_start,
    output logic             adc_busy,
    output logic             irq_req,
    output logic             dma_req,
    output logic             poll_en
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              start;
        logic              busy;
        logic              irq;
        logic              dma;
    } ctl_state_t;

    ctl_state_t st_q, st_d;
    mode_cfg_t  cfg;
    logic       pin_rise;
    logic       trig_hit;
    logic       accept;
    logic       finish;

    adc_tc_decode u_dec (
        .mode    (st_q.mode),
        .ext_sel (ext_sel),
        .cfg     (cfg)
    );

    adc_tc_edge #(.STAGES(SYNC_STGS)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_trig),
        .rise  (pin_rise)
    );

    always_comb begin
        unique case (cfg.src)
            SRC_SOFT: trig_hit = sw_trig;
            SRC_PACE: trig_hit = pacer_tick;
            SRC_PIN:  trig_hit = pin_rise;
            default:  trig_hit = 1'b0;
        endcase
        accept = trig_hit & ~st_q.busy;
        finish = adc_done & st_q.busy;

        st_d       = st_q;
        st_d.start = accept;
        if (accept)      st_d.busy = 1'b1;
        else if (finish) st_d.busy = 1'b0;

        if (finish && cfg.irq_en)        st_d.irq = 1'b1;
        else if (irq_clr || data_rd)     st_d.irq = 1'b0;

        if (finish && cfg.dma_en)        st_d.dma = 1'b1;
        else if (dma_ack)                st_d.dma = 1'b0;

        if (mode_we) begin
            st_d.mode = mode_wdata[MODE_W-1:0];
            st_d.irq  = 1'b0;
            st_d.dma  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign adc_start = st_q.start;
    assign adc_busy  = st_q.busy;
    assign irq_req   = st_q.irq;
    assign dma_req   = st_q.dma;
    assign poll_en   = cfg.poll_en;
endmodule

// File: rtl/adc_trig_ctrl_chk.sv
module adc_trig_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_we,
    input logic irq_clr,
    input logic data_rd,
    input logic dma_ack,
    input logic adc_done,
    input logic adc_start,
    input logic adc_busy,
    input logic irq_req,
    input logic dma_req
);
    // R4
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7
    busy_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> adc_busy);

    // R7
    busy_rise_by_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_busy) |-> adc_start);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_busy && !adc_done) |=> adc_busy);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !mode_we && !irq_clr && !data_rd) |=> irq_req);

    // R9
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !mode_we && !dma_ack) |=> dma_req);

    // R10
    write_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (!irq_req && !dma_req));

    // R5
    single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_req, dma_req}));
endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .irq_clr   (irq_clr),
    .data_rd   (data_rd),
    .dma_ack   (dma_ack),
    .adc_done  (adc_done),
    .adc_start (adc_start),
    .adc_busy  (adc_busy),
    .irq_req   (irq_req),
    .dma_req   (dma_req)
);

// File: tb/test_adc_trig_ctrl.sv
module test_adc_trig_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       ext_sel = 1'b0;
    logic       sw_trig = 1'b0, pacer_tick = 1'b0, ext_trig = 1'b0;
    logic       adc_done = 1'b0, irq_clr = 1'b0, data_rd = 1'b0, dma_ack = 1'b0;
    logic       adc_start, adc_busy, irq_req, dma_req, poll_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_trig_ctrl i_adc_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .ext_sel(ext_sel), .sw_trig(sw_trig), .pacer_tick(pacer_tick),
        .ext_trig(ext_trig), .adc_done(adc_done), .irq_clr(irq_clr),
        .data_rd(data_rd), .dma_ack(dma_ack), .adc_start(adc_start),
        .adc_busy(adc_busy), .irq_req(irq_req), .dma_req(dma_req),
        .poll_en(poll_en)
    );

    // reference model built from the requirements
    logic [2:0] m_mode;
    logic [2:0] m_sh;
    logic       m_start, m_busy, m_irq, m_dma;
    logic [4:0] m_cfg;
    logic       m_trig;

    // returns {src[1:0], irq_en, dma_en, poll_en}; src 0 off,1 sw,2 pacer,3 pin
    function automatic logic [4:0] ref_cfg(logic [2:0] m, logic e);
        case (m)
            3'b001:  return e ? 5'b00000 : 5'b01001;
            3'b010:  return e ? 5'b11010 : 5'b10010;
            3'b110:  return e ? 5'b11101 : 5'b10101;
            default: return 5'b00000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= '0; m_sh <= '0; m_start <= 0; m_busy <= 0; m_irq <= 0; m_dma <= 0;
        end else begin
            m_cfg = ref_cfg(m_mode, ext_sel);
            case (m_cfg[4:3])
                2'd1:    m_trig = sw_trig;
                2'd2:    m_trig = pacer_tick;
                2'd3:    m_trig = m_sh[1] & ~m_sh[2];
                default: m_trig = 1'b0;
            endcase
            m_sh    <= {m_sh[1:0], ext_trig};
            m_start <= m_trig & ~m_busy;
            m_busy  <= (m_trig & ~m_busy) ? 1'b1 : (adc_done ? 1'b0 : m_busy);
            if (mode_we) m_irq <= 1'b0;
            else if (adc_done && m_busy && m_cfg[2]) m_irq <= 1'b1;
            else if (irq_clr || data_rd) m_irq <= 1'b0;
            if (mode_we) m_dma <= 1'b0;
            else if (adc_done && m_busy && m_cfg[1]) m_dma <= 1'b1;
            else if (dma_ack) m_dma <= 1'b0;
            if (mode_we) m_mode <= mode_wdata[2:0];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(adc_start == m_start, "R4", "adc_start", adc_start, m_start);
        check(adc_busy == m_busy, "R7", "adc_busy", adc_busy, m_busy);
        check(irq_req == m_irq, "R8", "irq_req", irq_req, m_irq);
        check(dma_req == m_dma, "R9", "dma_req", dma_req, m_dma);
        check(poll_en == ref_cfg(m_mode, ext_sel)[0], "R2", "poll_en",
              poll_en, ref_cfg(m_mode, ext_sel)[0]);
    endtask

    task automatic idle_inputs();
        mode_we = 0; sw_trig = 0; pacer_tick = 0; adc_done = 0;
        irq_clr = 0; data_rd = 0; dma_ack = 0;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic do_reset(input logic sel);
        rst_n = 0; ext_sel = sel; ext_trig = 0; idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10
        check(!adc_start && !adc_busy && !irq_req && !dma_req && !poll_en,
              "R10", "outputs after reset",
              {adc_start, adc_busy, irq_req, dma_req, poll_en}, 0);
    endtask

    task automatic random_phase(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                logic [2:0] pick;
                case ($urandom_range(0, 4))
                    0: pick = 3'b001;
                    1: pick = 3'b010;
                    2: pick = 3'b110;
                    default: pick = 3'($urandom);
                endcase
                mode_we = 1;
                mode_wdata = {5'($urandom), pick};
            end
            sw_trig    = ($urandom_range(0, 9) == 0);
            pacer_tick = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 5) == 0) ext_trig = ~ext_trig;
            adc_done   = m_busy && ($urandom_range(0, 3) == 0);
            irq_clr    = ($urandom_range(0, 11) == 0);
            data_rd    = ($urandom_range(0, 11) == 0);
            dma_ack    = m_dma && ($urandom_range(0, 2) == 0);
            step();
        end
    endtask

    task automatic write_mode(input logic [7:0] v);
        mode_we = 1; mode_wdata = v;
        step();
    endtask

    initial begin
        void'($urandom(32'd1907));
        // internal jumper, directed cases
        do_reset(1'b0);
        write_mode(8'hF9);               // R1: upper bits set, code 001
        check(poll_en == 1, "R1", "poll_en after 0xF9", poll_en, 1);
        pacer_tick = 1; step();          // R3: pacer ignored in 001
        check(adc_start == 0, "R3", "pacer in soft mode", adc_start, 0);
        sw_trig = 1; step();
        check(adc_start == 1 && adc_busy == 1, "R3", "sw start", adc_start, 1);
        sw_trig = 1; step();             // R7: dropped while busy
        check(adc_start == 0, "R7", "trigger while busy", adc_start, 0);
        adc_done = 1; step();
        check(adc_busy == 0 && irq_req == 0 && dma_req == 0, "R3", "soft done no request",
              {adc_busy, irq_req, dma_req}, 0);
        write_mode(8'h06);               // R5: code 110
        pacer_tick = 1; step();
        adc_done = 1; irq_clr = 1; step();   // R8: set wins over clear
        check(irq_req == 1, "R8", "irq set with clear", irq_req, 1);
        repeat (3) step();
        check(irq_req == 1, "R8", "irq held", irq_req, 1);
        data_rd = 1; step();
        check(irq_req == 0, "R8", "irq cleared by read", irq_req, 0);
        write_mode(8'h02);               // R5: code 010
        check(poll_en == 0, "R5", "poll_en in dma mode", poll_en, 0);
        pacer_tick = 1; step();
        adc_done = 1; step();
        check(dma_req == 1, "R9", "dma raised", dma_req, 1);
        write_mode(8'h07);               // R10 abort, R2 unused code
        check(dma_req == 0, "R10", "dma aborted by write", dma_req, 0);
        pacer_tick = 1; sw_trig = 1; step();
        check(adc_start == 0 && poll_en == 0, "R2", "code 111 disabled", adc_start, 0);
        random_phase(4000);

        // external jumper
        do_reset(1'b1);
        write_mode(8'h01);
        sw_trig = 1; step();
        check(adc_start == 0 && poll_en == 0, "R3", "001 external disabled", adc_start, 0);
        write_mode(8'h12);               // code 010 with upper bits
        ext_trig = 1; pacer_tick = 1; step();   // sampled at this edge
        step();
        check(adc_start == 0, "R6", "pin not yet through sync", adc_start, 0);
        step();
        check(adc_start == 1, "R6", "pin start after sync", adc_start, 1);
        adc_done = 1; step();
        repeat (4) step();               // pin still high: no second strobe
        check(adc_start == 0 && adc_busy == 0, "R6", "one strobe per pulse", adc_start, 0);
        ext_trig = 0;
        random_phase(4000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule